// File: doc/BRIEF.md
# Timing-Pattern Output Sequencer

This block holds a list of entries, each a timer value paired with an output pattern. It drives the pattern of the current entry onto a parallel control bus (head-switch and servo bits) when a free-running external timer reaches that entry's timer value. Software loads entries through two write strobes, one per storage group, that share a single data bus. Each group holds ten entries. A group-select input chooses how the groups are used. With the select low, only the first group forms the sequence. With it high, the first group's entries run first and the second group's entries follow, giving a 20-step sequence.

Two run modes exist. In one-shot mode, each entry is removed once its pattern has gone out. When no entries remain, the block raises its empty flag and goes idle until new data arrives. In repeat mode the entries stay stored. An internal position steps through them and wraps from the last entry back to the first, so the same sequence plays again on each timer cycle. A start pulse from the timer logic puts the position back on the first entry. The output register keeps its last pattern between matches.

Top module: `pattern_fifo_seq`

## Requirements
- R1: After reset, `pat_out` is 0, `empty` is 1 and `overflow` is 0.
- R2: When `timer` equals the timer value of the current entry, `pat_out` shows that entry's pattern from the next clock onward. In all other cycles `pat_out` keeps its value.
- R3: A pulse on `wr_a` appends the pair (`wr_time`, `wr_pat`) to group A. A pulse on `wr_b` appends it to group B. Entries are used in the order they were written.
- R4: With `dual_grp` = 0, only group A entries form the sequence. Group B entries are never compared.
- R5: With `dual_grp` = 1, the sequence is all group A entries, followed by all group B entries.
- R6: With `loop_mode` = 0 (one-shot), an entry is removed from its group on the clock edge where it matches.
- R7: In one-shot mode, once the last entry has gone out, `empty` is 1 and `pat_out` stays unchanged until a new entry is written.
- R8: With `loop_mode` = 1 (repeat), matched entries stay stored. The position advances on each match and wraps from the last entry of the sequence back to the first.
- R9: With `loop_mode` = 1, a pulse on `restart` makes the first entry of the sequence the current entry for the next cycle.
- R10: A write to a group that already holds 10 entries is dropped. It also sets `overflow`, which stays at 1 until reset.
- R11: `empty` is 1 exactly when the active sequence (group A, plus group B when `dual_grp` = 1) holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_a | input | 1 | Append the data bus to group A |
| wr_b | input | 1 | Append the data bus to group B |
| wr_time | input | 16 | Timer value of the entry being written |
| wr_pat | input | 8 | Output pattern of the entry being written |
| dual_grp | input | 1 | 1: groups A then B (20 steps), 0: group A only |
| loop_mode | input | 1 | 1: repeat mode, 0: one-shot mode |
| timer | input | 16 | Running timer value |
| restart | input | 1 | Timer restart pulse; rewinds repeat mode |
| pat_out | output | 8 | Registered output pattern |
| empty | output | 1 | Active sequence holds no entries |
| overflow | output | 1 | Sticky flag for a write to a full group |

## Verification
The bench builds the block with its default parameters: 16-bit timer values, 8-bit patterns and ten entries per group. A group therefore fills after ten writes, which makes the dropped eleventh write and the sticky flag reachable in a short run. The full 20-step chained sequence and the wrap from the tail of group B back to the head of group A are also within reach. One-shot draining, loop wrap-around and restart rewinds are all driven by sweeping the timer input. The bench checks these against a queue model and also checks that group B stays unused in the ten-step setting.

// File: rtl/pfs_pkg.sv
// Shared definitions for the timing-pattern sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pfs_pkg;

    // Run mode of the sequencer.
    typedef enum logic {
        SEQ_ONCE   = 1'b0,
        SEQ_REPEAT = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/pfs_group.sv
// One storage group: a circular buffer of (timer value, pattern) pairs.
// Read is random access at an offset from the oldest entry.
// Assumes: pop is only asserted when cnt is non-zero; DEPTH >= 2.
module pfs_group #(
    parameter int TIME_W = 16,
    parameter int PAT_W  = 8,
    parameter int DEPTH  = 10,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TIME_W-1:0] push_time,
    input  logic [PAT_W-1:0]  push_pat,
    input  logic              pop,
    input  logic [IDX_W-1:0]  rd_ofs,
    output logic [CNT_W-1:0]  cnt,
    output logic [TIME_W-1:0] rd_time,
    output logic [PAT_W-1:0]  rd_pat
);

    logic [TIME_W-1:0] time_mem [DEPTH];
    logic [PAT_W-1:0]  pat_mem  [DEPTH];
    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  head_nxt;
    logic              accept;

    // Wraps a sum of two in-range indices back into 0..DEPTH-1.
    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W:0] a, input logic [IDX_W:0] b);
        logic [IDX_W:0] s;
        s = a + b;
        if (s >= (IDX_W+1)'(DEPTH)) s = s - (IDX_W+1)'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    // Address generation for write slot, read slot and next head.
    always_comb begin
        accept   = push && (cnt != CNT_W'(DEPTH));
        tail     = wrap_add({1'b0, head}, (IDX_W+1)'(cnt));
        rd_idx   = wrap_add({1'b0, head}, {1'b0, rd_ofs});
        head_nxt = wrap_add({1'b0, head}, (IDX_W+1)'(1));
        rd_time  = time_mem[rd_idx];
        rd_pat   = pat_mem[rd_idx];
    end

    // Entry storage; contents need no reset since cnt gates their use.
    always_ff @(posedge clk) begin
        if (accept) begin
            time_mem[tail] <= push_time;
            pat_mem[tail]  <= push_pat;
        end
    end

    // Head pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            cnt  <= '0;
        end else begin
            if (pop) head <= head_nxt;
            cnt <= cnt + CNT_W'(accept) - CNT_W'(pop);
        end
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt == CNT_W'(DEPTH)) |=> cnt == CNT_W'(DEPTH));
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);

endmodule

// File: rtl/pfs_pick.sv
// Selects the current entry of the sequence and compares it with the timer.
// In one-shot mode the current entry is the oldest of group A, else of B.
// In repeat mode it is the entry at the cursor position in the A-then-B list.
// Assumes: cnt inputs never exceed DEPTH.
module pfs_pick
    import pfs_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int PAT_W  = 8,
    parameter int DEPTH  = 10,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SEQ_W = $clog2(2 * DEPTH + 1)
) (
    input  seq_mode_e         mode,
    input  logic              dual,
    input  logic [SEQ_W-1:0]  cursor,
    input  logic [TIME_W-1:0] timer,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic [TIME_W-1:0] time_a,
    input  logic [TIME_W-1:0] time_b,
    input  logic [PAT_W-1:0]  pat_a,
    input  logic [PAT_W-1:0]  pat_b,
    output logic [IDX_W-1:0]  ofs_a,
    output logic [IDX_W-1:0]  ofs_b,
    output logic              valid,
    output logic              match,
    output logic              pop_a,
    output logic              pop_b,
    output logic [PAT_W-1:0]  sel_pat,
    output logic [SEQ_W-1:0]  next_pos
);

    logic [SEQ_W-1:0]  na;
    logic [SEQ_W-1:0]  nb;
    logic [SEQ_W-1:0]  total;
    logic [SEQ_W-1:0]  eff;
    logic [TIME_W-1:0] sel_time;
    logic              use_b;
    logic              once;

    // Entry selection, compare and next cursor position.
    always_comb begin
        na    = SEQ_W'(cnt_a);
        nb    = dual ? SEQ_W'(cnt_b) : '0;
        total = na + nb;
        valid = (total != '0);
        once  = (mode == SEQ_ONCE);
        if (once) begin
            eff   = '0;
            use_b = (na == '0);
            ofs_a = '0;
            ofs_b = '0;
        end else begin
            eff   = (cursor >= total) ? '0 : cursor;
            use_b = (eff >= na);
            ofs_a = IDX_W'(eff);
            ofs_b = IDX_W'(eff - na);
        end
        sel_time = use_b ? time_b : time_a;
        sel_pat  = use_b ? pat_b  : pat_a;
        match    = valid && (sel_time == timer);
        pop_a    = match && once && !use_b;
        pop_b    = match && once && use_b;
        next_pos = ((eff + SEQ_W'(1)) == total) ? '0 : eff + SEQ_W'(1);
    end

endmodule

// File: rtl/pattern_fifo_seq.sv
// Timing-pattern output sequencer: two groups of timer/pattern entries,
// a compare against an external timer, and a registered pattern output.
// Assumes: timer and restart come from timer logic in the same clock domain.
module pattern_fifo_seq
    import pfs_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int PAT_W  = 8,
    parameter int DEPTH  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [PAT_W-1:0]  wr_pat,
    input  logic              dual_grp,
    input  logic              loop_mode,
    input  logic [TIME_W-1:0] timer,
    input  logic              restart,
    output logic [PAT_W-1:0]  pat_out,
    output logic              empty,
    output logic              overflow
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SEQ_W = $clog2(2 * DEPTH + 1);
    localparam int NGRP  = 2;

    logic [NGRP-1:0]             g_push;
    logic [NGRP-1:0]             g_pop;
    logic [NGRP-1:0][IDX_W-1:0]  g_ofs;
    logic [NGRP-1:0][CNT_W-1:0]  g_cnt;
    logic [NGRP-1:0][TIME_W-1:0] g_time;
    logic [NGRP-1:0][PAT_W-1:0]  g_pat;
    logic [SEQ_W-1:0]            cursor;
    logic [SEQ_W-1:0]            next_pos;
    logic [PAT_W-1:0]            sel_pat;
    logic                        valid;
    logic                        match;
    logic                        full_hit;
    seq_mode_e                   mode;

    assign g_push = {wr_b, wr_a};
    assign mode   = loop_mode ? SEQ_REPEAT : SEQ_ONCE;

    // One storage group per write strobe.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pfs_group #(.TIME_W(TIME_W), .PAT_W(PAT_W), .DEPTH(DEPTH)) u_group (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (g_push[g]),
            .push_time (wr_time),
            .push_pat  (wr_pat),
            .pop       (g_pop[g]),
            .rd_ofs    (g_ofs[g]),
            .cnt       (g_cnt[g]),
            .rd_time   (g_time[g]),
            .rd_pat    (g_pat[g])
        );
    end

    pfs_pick #(.TIME_W(TIME_W), .PAT_W(PAT_W), .DEPTH(DEPTH)) u_pick (
        .mode     (mode),
        .dual     (dual_grp),
        .cursor   (cursor),
        .timer    (timer),
        .cnt_a    (g_cnt[0]),
        .cnt_b    (g_cnt[1]),
        .time_a   (g_time[0]),
        .time_b   (g_time[1]),
        .pat_a    (g_pat[0]),
        .pat_b    (g_pat[1]),
        .ofs_a    (g_ofs[0]),
        .ofs_b    (g_ofs[1]),
        .valid    (valid),
        .match    (match),
        .pop_a    (g_pop[0]),
        .pop_b    (g_pop[1]),
        .sel_pat  (sel_pat),
        .next_pos (next_pos)
    );

    // Detect a write aimed at a group that is already full.
    always_comb begin
        full_hit = (wr_a && g_cnt[0] == CNT_W'(DEPTH)) ||
                   (wr_b && g_cnt[1] == CNT_W'(DEPTH));
        empty    = !valid;
    end

    // Repeat-mode position: rewound by restart, stepped by each match.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cursor <= '0;
        else if (restart)              cursor <= '0;
        else if (loop_mode && match)   cursor <= next_pos;
    end

    // Output pattern register, loaded on a compare match.
    always_ff @(posedge clk) begin
        if (!rst_n)     pat_out <= '0;
        else if (match) pat_out <= sel_pat;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        overflow <= 1'b0;
        else if (full_hit) overflow <= 1'b1;
    end

    assert_pat_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pat_out == $past(sel_pat));
    assert_pat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pat_out));
    assert_idle_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> $stable(pat_out));
    assert_loop_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode && !wr_a) |=> g_cnt[0] >= $past(g_cnt[0]));
    assert_restart_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cursor == '0);
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: tb/pattern_fifo_seq_bench.sv
// Bench with a behavioural queue model compared on every clock.
module pattern_fifo_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TIME_W = 16;
    localparam int PAT_W  = 8;
    localparam int DEPTH  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_a = 1'b0;
    logic              wr_b = 1'b0;
    logic [TIME_W-1:0] wr_time = '0;
    logic [PAT_W-1:0]  wr_pat = '0;
    logic              dual_grp = 1'b0;
    logic              loop_mode = 1'b0;
    logic [TIME_W-1:0] timer = 16'hFFFF;
    logic              restart = 1'b0;
    logic [PAT_W-1:0]  pat_out;
    logic              empty;
    logic              overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Reference model state.
    int qa_t[$], qa_p[$], qb_t[$], qb_p[$];
    int m_pat = 0;
    int m_ovf = 0;
    int m_cur = 0;
    int na, nb, tot, eff, et, ep, nxt;
    bit ub, hit, fa, fb;

    pattern_fifo_seq #(.TIME_W(TIME_W), .PAT_W(PAT_W), .DEPTH(DEPTH)) u_pattern_fifo_seq (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wr_time(wr_time),
        .wr_pat(wr_pat), .dual_grp(dual_grp), .loop_mode(loop_mode), .timer(timer),
        .restart(restart), .pat_out(pat_out), .empty(empty), .overflow(overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model update at each rising edge, from the inputs held since the last falling edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            qa_t = {}; qa_p = {}; qb_t = {}; qb_p = {};
            m_pat = 0; m_ovf = 0; m_cur = 0;
        end else begin
            na = qa_t.size(); nb = qb_t.size();
            tot = na + (dual_grp ? nb : 0);
            fa = (na == DEPTH); fb = (nb == DEPTH);
            hit = 1'b0; ub = 1'b0; nxt = 0;
            if (tot > 0) begin
                if (!loop_mode) begin
                    ub = (na == 0);
                    et = ub ? qb_t[0] : qa_t[0];
                    ep = ub ? qb_p[0] : qa_p[0];
                end else begin
                    eff = (m_cur >= tot) ? 0 : m_cur;
                    ub = (eff >= na);
                    et = ub ? qb_t[eff - na] : qa_t[eff];
                    ep = ub ? qb_p[eff - na] : qa_p[eff];
                    nxt = (eff + 1 == tot) ? 0 : eff + 1;
                end
                hit = (et == int'(timer));
            end
            if (hit) begin
                m_pat = ep;
                if (!loop_mode) begin
                    if (ub) begin void'(qb_t.pop_front()); void'(qb_p.pop_front()); end
                    else    begin void'(qa_t.pop_front()); void'(qa_p.pop_front()); end
                end
            end
            if (restart) m_cur = 0;
            else if (loop_mode && hit) m_cur = nxt;
            if (wr_a) begin
                if (fa) m_ovf = 1;
                else begin qa_t.push_back(int'(wr_time)); qa_p.push_back(int'(wr_pat)); end
            end
            if (wr_b) begin
                if (fb) m_ovf = 1;
                else begin qb_t.push_back(int'(wr_time)); qb_p.push_back(int'(wr_pat)); end
            end
        end
    end

    // Compare the outputs against the model at every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(int'(pat_out) == m_pat, "R2 pat_out", int'(pat_out), m_pat);
            chk(int'(empty) == int'((qa_t.size() + (dual_grp ? qb_t.size() : 0)) == 0),
                "R11 empty", int'(empty), int'((qa_t.size() + (dual_grp ? qb_t.size() : 0)) == 0));
            chk(int'(overflow) == m_ovf, "R10 overflow", int'(overflow), m_ovf);
        end
    end

    task automatic nx();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input bit grp_b, input int t, input int p);
        nx();
        wr_a = !grp_b; wr_b = grp_b;
        wr_time = TIME_W'(t); wr_pat = PAT_W'(p);
        timer = 16'hFFFF;
        nx();
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int t = lo; t <= hi; t++) begin
            nx();
            timer = TIME_W'(t);
        end
        nx();
        timer = 16'hFFFF;
        nx();
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) nx();
        cmp_on = 1'b1;
        // R1: reset values.
        chk(pat_out == '0, "R1 pat_out", int'(pat_out), 0);
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        rst_n = 1'b1;
        nx();

        // R3/R4/R6: one-shot, ten-step; group B holds an entry that must stay unused.
        wr(1'b0, 5, 8'h11); wr(1'b0, 8, 8'h22); wr(1'b0, 12, 8'h33);
        wr(1'b1, 6, 8'h99);
        sweep(0, 20);
        chk(pat_out == 8'h33, "R4 group B unused", int'(pat_out), 8'h33);
        chk(empty == 1'b1, "R6 entries removed", int'(empty), 1);
        // R7: stays idle after the last entry.
        sweep(0, 20);
        chk(pat_out == 8'h33, "R7 idle after last", int'(pat_out), 8'h33);

        // R5: twenty-step chaining, A before B.
        dual_grp = 1'b1;
        wr(1'b0, 3, 8'h44);
        sweep(0, 4);
        chk(pat_out == 8'h44, "R5 group A first", int'(pat_out), 8'h44);
        sweep(5, 10);
        chk(pat_out == 8'h99, "R5 group B follows", int'(pat_out), 8'h99);

        // R8: repeat mode keeps entries and wraps.
        loop_mode = 1'b1;
        wr(1'b0, 2, 8'hA1); wr(1'b0, 4, 8'hA2); wr(1'b1, 7, 8'hB1);
        sweep(0, 9);
        sweep(0, 3);
        chk(pat_out == 8'hA1, "R8 wrap to first", int'(pat_out), 8'hA1);
        chk(empty == 1'b0, "R8 entries kept", int'(empty), 0);

        // R9: restart rewinds to the first entry.
        sweep(4, 5);
        nx(); restart = 1'b1;
        nx(); restart = 1'b0;
        sweep(2, 2);
        chk(pat_out == 8'hA1, "R9 restart rewinds", int'(pat_out), 8'hA1);

        // Drain in one-shot mode.
        loop_mode = 1'b0;
        sweep(0, 9);
        chk(empty == 1'b1, "R6 drained", int'(empty), 1);

        // R10: eleventh write to a full group is dropped.
        dual_grp = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) wr(1'b0, 1000 + i, 8'h50 + i);
        chk(overflow == 1'b1, "R10 flag set", int'(overflow), 1);
        sweep(1000, 1010);
        chk(pat_out == 8'h59, "R10 dropped entry", int'(pat_out), 8'h59);
        chk(overflow == 1'b1, "R10 sticky", int'(overflow), 1);

        repeat (2) nx();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule